// File: doc/BRIEF.md
# Split-Transaction Read Fabric

This block connects a set of requesters and a set of memory-like targets over one shared bus. A read on that bus takes two separate bus cycles. In the first, the requester wins arbitration and drives the target number, the address and its own tag for one clock. It then lets go of the bus. The target queues the read and works on it for a fixed number of clocks while the bus carries other traffic. In the second, the target wins arbitration as a bus master in its own right. It drives the data for one clock with the requester's tag, and only the requester whose tag matches takes the data.

A fixed-priority arbiter decides who owns the bus. Its grant is registered, so a winner drives on the clock after it asked. Targets always come before requesters, and within each group the lower index wins. Each target holds up to `QD` reads. When its queue is full it refuses a command by leaving the acknowledge line low, and the refused requester asks for the bus again without any help from outside. Each target returns a fixed data pattern, so read results can be predicted without a memory model.

Top module: `split_rd_bus`

## Requirements
- R1: While reset is held and on the first cycle after it, every `busy` bit and every `rsp_valid` bit is 0.
- R2: A read from target t at address a returns a word whose upper DW-AW bits hold t+1 and whose lower AW bits hold the bitwise inverse of a. Only the issuing requester pulses `rsp_valid`, for one cycle.
- R3: With no other traffic, `rsp_valid` rises LAT+4 clock edges after the edge that samples `issue`. `busy` stays high from the edge after `issue` until that edge.
- R4: At most one master owns the bus in any cycle. A master owns it for exactly one clock, starting on the clock after it asked. Two commands may use the bus on back-to-back clocks.
- R5: When a target reply and a requester command ask for the bus in the same cycle, the reply wins and the command moves one clock later.
- R6: Among requesters asking in the same cycle, the lower index is granted first.
- R7: A target holds at most QD reads. A command that reaches a full target is refused, and the requester retries until a slot frees. Its data is still returned correctly.
- R8: An `issue` pulse to a requester whose `busy` is high is ignored. It causes no second reply and does not change the address being read.
- R9: Each target returns its replies in the order it accepted the commands. It does not start a new reply on the clock that follows one of its own replies.
- R10: The bus is free while a target works on a read. A second requester's read to another target that is issued at the same time finishes LAT+5 edges after issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | NR | One bit per requester: start a read (sampled only when idle) |
| issue_tgt | input | NR*TW | Target number for each requester, slice i belongs to requester i |
| issue_addr | input | NR*AW | Read address for each requester, slice i belongs to requester i |
| busy | output | NR | Requester has a read in flight |
| rsp_valid | output | NR | One-cycle pulse when the read data arrives |
| rsp_data | output | NR*DW | Captured read data per requester, valid with `rsp_valid` |

## Verification
Timing is checked to the exact edge, because a one-clock slip in grant timing, in reply priority or in the bus hold time shows up only as a latency that is off by one. The bench creates a collision between a reply and a new command. If the priority were reversed, the first reader's latency would grow and the second one's would shrink. It also sends five reads at once to a target that holds four. A design that overwrote a full queue would return wrong data or lose a reply, and one that stalled the refused requester would never finish. A further test issues again while `busy` is high: a requester that took that command would return the second address or reply twice.

// File: rtl/split_rd_pkg.sv
package split_rd_pkg;

    typedef enum logic [1:0] {
        RQ_IDLE = 2'd0,
        RQ_ARB  = 2'd1,
        RQ_WAIT = 2'd2
    } rq_state_t;

    // index width that never collapses to zero bits
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/split_rd_arbiter.sv
module split_rd_arbiter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt_q
);
    logic [N-1:0] win;
    logic         taken;

    // lowest index wins; slot order puts targets first
    always_comb begin
        win   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                win[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) gnt_q <= '0;
        else     gnt_q <= win;
    end
endmodule

// File: rtl/split_rd_requester.sv
module split_rd_requester
    import split_rd_pkg::*;
#(
    parameter int IDX = 0,
    parameter int TW  = 1,
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int IW  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [TW-1:0] issue_tgt,
    input  logic [AW-1:0] issue_addr,
    input  logic          gnt,
    input  logic          bus_ack,
    input  logic          rsp_v,
    input  logic [IW-1:0] rsp_id,
    input  logic [DW-1:0] rsp_word,
    output logic          req,
    output logic [TW-1:0] cmd_tgt,
    output logic [AW-1:0] cmd_addr,
    output logic          busy,
    output logic          got,
    output logic [DW-1:0] got_data
);
    rq_state_t     state;
    logic [TW-1:0] tgt_q;
    logic [AW-1:0] addr_q;
    logic          mine;

    assign mine     = rsp_v && (rsp_id == IW'(IDX));
    assign req      = (state == RQ_ARB) && !gnt;
    assign cmd_tgt  = tgt_q;
    assign cmd_addr = addr_q;
    assign busy     = (state != RQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RQ_IDLE;
            tgt_q    <= '0;
            addr_q   <= '0;
            got      <= 1'b0;
            got_data <= '0;
        end else begin
            got <= 1'b0;
            unique case (state)
                RQ_IDLE: if (issue) begin
                    tgt_q  <= issue_tgt;
                    addr_q <= issue_addr;
                    state  <= RQ_ARB;
                end
                RQ_ARB: if (gnt && bus_ack) state <= RQ_WAIT;
                RQ_WAIT: if (mine) begin
                    got      <= 1'b1;
                    got_data <= rsp_word;
                    state    <= RQ_IDLE;
                end
                default: state <= RQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/split_rd_target.sv
module split_rd_target #(
    parameter int TIDX = 0,
    parameter int TW   = 1,
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int IW   = 3,
    parameter int QD   = 4,
    parameter int LAT  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_v,
    input  logic [TW-1:0]          cmd_tgt,
    input  logic [AW-1:0]          cmd_addr,
    input  logic [IW-1:0]          cmd_id,
    input  logic                   gnt,
    output logic                   accept,
    output logic                   req,
    output logic [IW-1:0]          rep_id,
    output logic [DW-1:0]          rep_data,
    output logic [$clog2(QD+1)-1:0] occ
);
    localparam int PW = (QD > 1) ? $clog2(QD) : 1;
    localparam int CW = $clog2(LAT + 2);
    localparam int OW = $clog2(QD + 1);

    logic [AW-1:0] q_addr [QD];
    logic [IW-1:0] q_id   [QD];
    logic [CW-1:0] q_cnt  [QD];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          head_ready, push, pop;

    assign accept     = cmd_v && (cmd_tgt == TW'(TIDX)) && (occ < OW'(QD));
    assign push       = accept;
    assign pop        = gnt;
    assign head_ready = (occ != '0) && (q_cnt[rd_ptr] == '0);
    assign req        = head_ready && !gnt;
    assign rep_id     = q_id[rd_ptr];
    assign rep_data   = {(DW-AW)'(TIDX + 1), ~q_addr[rd_ptr]};

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(QD - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
            for (int e = 0; e < QD; e++) begin
                q_addr[e] <= '0;
                q_id[e]   <= '0;
                q_cnt[e]  <= '0;
            end
        end else begin
            for (int e = 0; e < QD; e++) begin
                if (push && (wr_ptr == PW'(e))) begin
                    q_addr[e] <= cmd_addr;
                    q_id[e]   <= cmd_id;
                    q_cnt[e]  <= CW'(LAT);
                end else if (q_cnt[e] != '0) begin
                    q_cnt[e] <= q_cnt[e] - 1'b1;
                end
            end
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/split_rd_bus.sv
module split_rd_bus
    import split_rd_pkg::*;
#(
    parameter int NR  = 6,
    parameter int NT  = 2,
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int QD  = 4,
    parameter int LAT = 8,
    parameter int TW  = idx_width(NT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NR-1:0]    issue,
    input  logic [NR*TW-1:0] issue_tgt,
    input  logic [NR*AW-1:0] issue_addr,
    output logic [NR-1:0]    busy,
    output logic [NR-1:0]    rsp_valid,
    output logic [NR*DW-1:0] rsp_data
);
    localparam int IW = idx_width(NR);
    localparam int NM = NT + NR;
    localparam int OW = $clog2(QD + 1);

    logic [NM-1:0]    arb_req;
    logic [NM-1:0]    gnt_q;
    logic [NT*OW-1:0] tgt_occ;

    logic [TW-1:0] m_tgt  [NR];
    logic [AW-1:0] m_addr [NR];
    logic [IW-1:0] t_id   [NT];
    logic [DW-1:0] t_data [NT];
    logic [NT-1:0] t_acc;

    logic          cmd_v, rsp_v, bus_ack;
    logic [TW-1:0] bus_tgt;
    logic [AW-1:0] bus_addr;
    logic [IW-1:0] bus_id, rsp_id;
    logic [DW-1:0] rsp_word;

    split_rd_arbiter #(.N(NM)) u_arb (
        .clk(clk), .rst(rst), .req(arb_req), .gnt_q(gnt_q)
    );

    // shared bus: the single granted master drives it
    always_comb begin
        cmd_v    = 1'b0;
        bus_tgt  = '0;
        bus_addr = '0;
        bus_id   = '0;
        for (int i = 0; i < NR; i++) begin
            if (gnt_q[NT+i]) begin
                cmd_v    = 1'b1;
                bus_tgt  = m_tgt[i];
                bus_addr = m_addr[i];
                bus_id   = IW'(i);
            end
        end
        rsp_v    = 1'b0;
        rsp_id   = '0;
        rsp_word = '0;
        for (int t = 0; t < NT; t++) begin
            if (gnt_q[t]) begin
                rsp_v    = 1'b1;
                rsp_id   = t_id[t];
                rsp_word = t_data[t];
            end
        end
    end

    assign bus_ack = |t_acc;

    for (genvar t = 0; t < NT; t++) begin : g_tgt
        split_rd_target #(
            .TIDX(t), .TW(TW), .AW(AW), .DW(DW), .IW(IW), .QD(QD), .LAT(LAT)
        ) u_tgt (
            .clk(clk), .rst(rst),
            .cmd_v(cmd_v), .cmd_tgt(bus_tgt), .cmd_addr(bus_addr), .cmd_id(bus_id),
            .gnt(gnt_q[t]),
            .accept(t_acc[t]), .req(arb_req[t]),
            .rep_id(t_id[t]), .rep_data(t_data[t]),
            .occ(tgt_occ[t*OW +: OW])
        );
    end

    for (genvar i = 0; i < NR; i++) begin : g_req
        split_rd_requester #(
            .IDX(i), .TW(TW), .AW(AW), .DW(DW), .IW(IW)
        ) u_req (
            .clk(clk), .rst(rst),
            .issue(issue[i]),
            .issue_tgt(issue_tgt[i*TW +: TW]),
            .issue_addr(issue_addr[i*AW +: AW]),
            .gnt(gnt_q[NT+i]), .bus_ack(bus_ack),
            .rsp_v(rsp_v), .rsp_id(rsp_id), .rsp_word(rsp_word),
            .req(arb_req[NT+i]),
            .cmd_tgt(m_tgt[i]), .cmd_addr(m_addr[i]),
            .busy(busy[i]),
            .got(rsp_valid[i]), .got_data(rsp_data[i*DW +: DW])
        );
    end
endmodule

// File: rtl/split_rd_bus_chk.sv
module split_rd_bus_chk #(
    parameter int NR = 6,
    parameter int NT = 2,
    parameter int QD = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NT+NR-1:0]             gnt_q,
    input logic [NT+NR-1:0]             arb_req,
    input logic [NT*$clog2(QD+1)-1:0]   tgt_occ,
    input logic [NR-1:0]                busy,
    input logic [NR-1:0]                rsp_valid
);
    localparam int NM = NT + NR;
    localparam int OW = $clog2(QD + 1);

    assert_single_owner_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_q));

    assert_reply_beats_cmd_R5: assert property (@(posedge clk) disable iff (rst)
        (|arb_req[NT-1:0]) |=> !(|gnt_q[NM-1:NT]));

    for (genvar m = 0; m < NM; m++) begin : g_m
        assert_grant_follows_req_R4: assert property (@(posedge clk) disable iff (rst)
            gnt_q[m] |-> $past(arb_req[m]));
        assert_one_clock_hold_R4: assert property (@(posedge clk) disable iff (rst)
            gnt_q[m] |=> !gnt_q[m]);
    end

    for (genvar t = 0; t < NT; t++) begin : g_t
        assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
            tgt_occ[t*OW +: OW] <= OW'(QD));
    end

    for (genvar i = 0; i < NR; i++) begin : g_r
        assert_reply_only_when_waiting_R2: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[i] |-> $past(busy[i]));
    end
endmodule

bind split_rd_bus split_rd_bus_chk #(.NR(NR), .NT(NT), .QD(QD)) u_chk (
    .clk(clk), .rst(rst), .gnt_q(gnt_q), .arb_req(arb_req),
    .tgt_occ(tgt_occ), .busy(busy), .rsp_valid(rsp_valid)
);

// File: tb/split_rd_bus_test.sv
module split_rd_bus_test;
    localparam int NR  = 6;
    localparam int NT  = 2;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int QD  = 4;
    localparam int LAT = 8;
    localparam int TW  = 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NR-1:0]    issue = '0;
    logic [NR*TW-1:0] issue_tgt = '0;
    logic [NR*AW-1:0] issue_addr = '0;
    logic [NR-1:0]    busy, rsp_valid;
    logic [NR*DW-1:0] rsp_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int rcv_cnt [NR];
    int rcv_cyc [NR];
    logic [DW-1:0] rcv_dat [NR];

    split_rd_bus #(.NR(NR), .NT(NT), .AW(AW), .DW(DW), .QD(QD), .LAT(LAT)) uut (
        .clk(clk), .rst(rst), .issue(issue), .issue_tgt(issue_tgt),
        .issue_addr(issue_addr), .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial for (int i = 0; i < NR; i++) begin
        rcv_cnt[i] = 0; rcv_cyc[i] = 0; rcv_dat[i] = '0;
    end

    always @(negedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (rsp_valid[i]) begin
                rcv_cnt[i] = rcv_cnt[i] + 1;
                rcv_cyc[i] = cyc;
                rcv_dat[i] = rsp_data[i*DW +: DW];
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_ge(input string tag, input int act, input int lo);
        total++;
        if (act < lo) begin
            bad++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lo);
        end
    endtask

    function automatic int expect_word(input int t, input int a);
        logic [AW-1:0] na;
        na = ~AW'(a);
        return int'({(DW-AW)'(t + 1), na});
    endfunction

    task automatic set_cmd(input int i, input int t, input int a);
        issue_tgt[i*TW +: TW]  = TW'(t);
        issue_addr[i*AW +: AW] = AW'(a);
    endtask

    task automatic go(input logic [NR-1:0] mask, output int e0);
        @(negedge clk);
        issue = mask;
        e0 = cyc + 1;
        @(negedge clk);
        issue = '0;
    endtask

    task automatic wait_cnt(input int i, input int n);
        int guard = 0;
        while (rcv_cnt[i] < n && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 rsp_valid in reset", int'(rsp_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
    endtask

    task automatic t_single;
        int e0, c0, c1;
        set_cmd(0, 0, 8'h5A);
        c1 = rcv_cnt[1];
        go(6'b000001, e0);
        check("R3 busy while in flight", int'(busy[0]), 1);
        wait_cnt(0, 1);
        check("R3 solo latency", rcv_cyc[0] - e0, LAT + 4);
        check("R2 data", int'(rcv_dat[0]), expect_word(0, 8'h5A));
        check("R2 other requester untouched", rcv_cnt[1], c1);
        c0 = rcv_cnt[0];
        idle(2);
        check("R2 single pulse", rcv_cnt[0], c0);
        check("R3 busy cleared", int'(busy[0]), 0);
    endtask

    task automatic t_concurrent;
        int e0, b0, b1;
        b0 = rcv_cnt[0]; b1 = rcv_cnt[1];
        set_cmd(0, 0, 8'h11);
        set_cmd(1, 1, 8'h22);
        go(6'b000011, e0);
        wait_cnt(0, b0 + 1);
        wait_cnt(1, b1 + 1);
        check("R6 lower index first", rcv_cyc[0] - e0, LAT + 4);
        check("R10 R4 second command next clock", rcv_cyc[1] - e0, LAT + 5);
        check("R2 data req0", int'(rcv_dat[0]), expect_word(0, 8'h11));
        check("R2 data req1", int'(rcv_dat[1]), expect_word(1, 8'h22));
    endtask

    task automatic t_priority;
        int e0, e4, b3, b4;
        b3 = rcv_cnt[3]; b4 = rcv_cnt[4];
        set_cmd(3, 0, 8'h33);
        set_cmd(4, 1, 8'h44);
        go(6'b001000, e0);
        while (cyc != e0 + LAT + 1) @(negedge clk);
        issue = 6'b010000;
        e4 = cyc + 1;
        @(negedge clk);
        issue = '0;
        wait_cnt(3, b3 + 1);
        wait_cnt(4, b4 + 1);
        check("R5 reply not delayed", rcv_cyc[3] - e0, LAT + 4);
        check("R5 command yields one clock", rcv_cyc[4] - e4, LAT + 5);
        check("R2 data req3", int'(rcv_dat[3]), expect_word(0, 8'h33));
        check("R2 data req4", int'(rcv_dat[4]), expect_word(1, 8'h44));
    endtask

    task automatic t_fill;
        int e0;
        int base [5];
        for (int i = 0; i < 5; i++) begin
            base[i] = rcv_cnt[i];
            set_cmd(i, 0, 8'h80 + i);
        end
        go(6'b011111, e0);
        for (int i = 0; i < 5; i++) wait_cnt(i, base[i] + 1);
        for (int i = 0; i < 4; i++) begin
            check($sformatf("R9 order slot %0d", i), rcv_cyc[i] - e0, LAT + 4 + 2 * i);
            check($sformatf("R7 data slot %0d", i), int'(rcv_dat[i]), expect_word(0, 8'h80 + i));
        end
        check_ge("R7 refused command retried later", rcv_cyc[4] - e0, 2 * LAT + 6);
        check("R7 data after retry", int'(rcv_dat[4]), expect_word(0, 8'h84));
    endtask

    task automatic t_ignore_busy;
        int e0, b2;
        b2 = rcv_cnt[2];
        set_cmd(2, 1, 8'hA1);
        go(6'b000100, e0);
        idle(2);
        set_cmd(2, 0, 8'hB2);
        @(negedge clk);
        issue = 6'b000100;
        @(negedge clk);
        issue = '0;
        wait_cnt(2, b2 + 1);
        check("R8 first address kept", int'(rcv_dat[2]), expect_word(1, 8'hA1));
        check("R8 latency unchanged", rcv_cyc[2] - e0, LAT + 4);
        idle(3 * LAT + 10);
        check("R8 no second reply", rcv_cnt[2], b2 + 1);
        check("R8 not busy afterwards", int'(busy[2]), 0);
    endtask

    initial begin
        t_reset();
        idle(2);
        t_single();
        idle(20);
        t_concurrent();
        idle(20);
        t_priority();
        idle(20);
        t_fill();
        idle(20);
        t_ignore_busy();
        idle(5);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule